// File: doc/BRIEF.md
# Multi-Mode Acquisition Memory Sequencer

This block decides which incoming 12-bit samples are written into a circular sample memory, and at which addresses. A sample-valid strobe brings in the data. A qualified trigger input marks the event of interest. The block places the capture around that event in one of five ways:

- storing only after the event,
- keeping a history before the event and a fixed tail after it,
- centring the event in memory,
- running freely with no regard to the event,
- taking back-to-back segments that re-arm immediately.

A start command loads the mode and the counts and begins a run. A stop command ends any run early.

The memory itself lives outside the block. The block drives a registered write port with address, data and enable. It also reports three things for the readout logic: the address of the trigger sample, the number of completed segments, and a done flag together with the last address written. Generating the sample clock, producing the trigger, and reading or analysing the stored data belong to other blocks.

Top module: `acq_seq_core`

## Requirements
- R1: After synchronous reset, wr_en, done, rec_count, trig_addr and last_addr are all 0, and no sample is written until a start command is accepted.
- R2: Mode code 0 (and the unused codes 5, 6, 7) is post-trigger mode. No sample is written until the first valid sample with the trigger high; that sample and the following count-1 valid samples are written, then done rises. A count of 0 selects the default depth-100 (depth/2 when the depth is not above 200).
- R3: Mode code 1 is pre-trigger mode. Every valid sample is written from the start. A trigger is accepted only once at least depth-count samples have already been written. The trigger sample and the following count-1 valid samples are then written, and done rises.
- R4: Mode code 2 is centre mode. The pre-trigger portion is depth/2 samples. The trigger sample and depth/2-1 further samples follow, whatever the count input holds.
- R5: Mode code 3 is free-run mode. Every valid sample is written until a stop command arrives, and the trigger has no effect: trig_addr stays 0.
- R6: Mode code 4 is segmented record mode. Each segment starts at an accepted trigger and holds count samples. The very next valid sample after a segment's last may trigger the next segment. rec_count increments when each segment ends. Done rises when rec_count reaches the segment target; a target of 0 acts as 1.
- R7: trig_addr holds the write address of the most recently accepted trigger sample of the run.
- R8: A stop command in any running state ends the run, and done is high on the next cycle. A sample valid in the stop cycle is not written. last_addr holds the address of the last sample written in the run, or 0 if none was written.
- R9: The write port is registered: a sample accepted in cycle t appears on wr_en/wr_addr/wr_data in cycle t+1. Addresses start at 0 on every accepted start, step by one per write, and wrap modulo the depth.
- R10: A start command is accepted only when idle. On acceptance it latches the mode, count and segment target, and clears done, rec_count, trig_addr and last_addr. A start command during a run is ignored, as is a stop command while idle. A count above the depth is treated as the depth.
- R11: A trigger counts only in a cycle in which smp_vld is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | A new sample is present this cycle |
| smp_data | input | DATA_W | Sample value |
| trig_in | input | 1 | Qualified trigger, sampled with smp_vld |
| start_cmd | input | 1 | Begin a run (accepted when idle) |
| stop_cmd | input | 1 | Abort the current run |
| mode_sel | input | 3 | Capture mode code |
| cnt_in | input | ADDR_W+1 | Samples after trigger / per segment |
| rec_in | input | REC_W | Segment target for record mode |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| trig_addr | output | ADDR_W | Address of the latest accepted trigger sample |
| rec_count | output | REC_W | Completed segments in this run |
| last_addr | output | ADDR_W | Address of the last sample written |
| done | output | 1 | Run finished or stopped |

## Verification
The bench holds the trigger high from the first cycle of pre-trigger and centre runs. A design that ignored the history requirement would latch the trigger at address 0 rather than at depth-count or depth/2. In segmented mode it keeps the trigger high across segment ends. A design needing more than one sample to re-arm would leave a gap in the write addresses, miscount segments, or finish at the wrong last address. It also drives a stop together with a valid sample, a start in mid-run with a different mode, a trigger with no valid sample, a count of zero and a count above the depth. A wrong design would then store an extra sample, switch modes, fire early, or store the wrong number of samples; every cycle is compared against a behavioural model.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [2:0] {
    M_POST   = 3'd0,
    M_PRE    = 3'd1,
    M_CENTRE = 3'd2,
    M_FREE   = 3'd3,
    M_REC    = 3'd4
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_FREE = 3'd4
  } state_t;

  function automatic mode_t decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return M_PRE;
      3'd2:    return M_CENTRE;
      3'd3:    return M_FREE;
      3'd4:    return M_REC;
      default: return M_POST;
    endcase
  endfunction

endpackage

// File: rtl/acq_cfg_latch.sv
module acq_cfg_latch
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int REC_W       = 16,
  parameter int DFLT_MARGIN = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [2:0]        mode_sel,
  input  logic [ADDR_W:0]   cnt_in,
  input  logic [REC_W-1:0]  rec_in,
  output mode_t             mode_dec,
  output mode_t             mode_q,
  output logic [ADDR_W:0]   cnt_eff,
  output logic [ADDR_W:0]   pre_need,
  output logic [REC_W-1:0]  rec_tgt
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DFLT  = (DEPTH > 2 * DFLT_MARGIN) ? DEPTH - DFLT_MARGIN : DEPTH / 2;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] DFLT_C  = CNT_W'(DFLT);

  logic [CNT_W-1:0] cnt_cl, cnt_n, need_n;

  assign mode_dec = decode_mode(mode_sel);

  always_comb begin
    if (cnt_in == '0)           cnt_cl = DFLT_C;
    else if (cnt_in > DEPTH_C)  cnt_cl = DEPTH_C;
    else                        cnt_cl = cnt_in;
    case (mode_dec)
      M_CENTRE: begin cnt_n = HALF_C; need_n = HALF_C;           end
      M_PRE:    begin cnt_n = cnt_cl; need_n = DEPTH_C - cnt_cl; end
      default:  begin cnt_n = cnt_cl; need_n = '0;               end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_POST;
      cnt_eff  <= DFLT_C;
      pre_need <= '0;
      rec_tgt  <= '0;
    end else if (load) begin
      mode_q   <= mode_dec;
      cnt_eff  <= cnt_n;
      pre_need <= need_n;
      rec_tgt  <= rec_in;
    end
  end

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int REC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              smp_vld,
  input  logic              trig_in,
  input  mode_t             mode_dec,
  input  mode_t             mode_q,
  input  logic [ADDR_W:0]   cnt_eff,
  input  logic [ADDR_W:0]   pre_need,
  input  logic [REC_W-1:0]  rec_tgt,
  output logic              start_go,
  output logic              wr_req,
  output logic              trig_acc,
  output state_t            st_q,
  output logic [REC_W-1:0]  rec_count,
  output logic              done
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] post_left;
  logic [CNT_W-1:0] pre_seen;
  logic [REC_W:0]   recs_p1;
  logic             pre_ok, live, seg_end, last_seg, stream;

  assign live     = smp_vld && !stop_cmd;
  assign pre_ok   = pre_seen >= pre_need;
  assign start_go = (st_q == ST_IDLE) && start_cmd;
  assign trig_acc = live && trig_in &&
                    (((st_q == ST_PRE) && pre_ok) || (st_q == ST_WAIT));
  assign stream   = live && ((st_q == ST_FREE) || (st_q == ST_PRE) || (st_q == ST_POST));
  assign wr_req   = stream || trig_acc;
  assign seg_end  = (trig_acc && (cnt_eff == ONE_C)) ||
                    ((st_q == ST_POST) && live && (post_left == ONE_C));
  assign recs_p1  = {1'b0, rec_count} + 1'b1;
  assign last_seg = (mode_q != M_REC) || (recs_p1 >= {1'b0, rec_tgt});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      post_left <= '0;
      pre_seen  <= '0;
      rec_count <= '0;
      done      <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_cmd) begin
        done      <= 1'b0;
        rec_count <= '0;
        pre_seen  <= '0;
        post_left <= '0;
        case (mode_dec)
          M_PRE, M_CENTRE: st_q <= ST_PRE;
          M_FREE:          st_q <= ST_FREE;
          default:         st_q <= ST_WAIT;
        endcase
      end
    end else if (stop_cmd) begin
      st_q <= ST_IDLE;
      done <= 1'b1;
    end else begin
      if (st_q == ST_PRE && live && !trig_acc && pre_seen < DEPTH_C)
        pre_seen <= pre_seen + 1'b1;
      if (trig_acc)
        post_left <= cnt_eff - 1'b1;
      else if (st_q == ST_POST && live)
        post_left <= post_left - 1'b1;
      if (seg_end) begin
        if (mode_q == M_REC) rec_count <= recs_p1[REC_W-1:0];
        if (last_seg) begin
          st_q <= ST_IDLE;
          done <= 1'b1;
        end else begin
          st_q <= ST_WAIT;
        end
      end else if (trig_acc) begin
        st_q <= ST_POST;
      end
    end
  end

endmodule

// File: rtl/acq_wr_port.sv
module acq_wr_port #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_req,
  input  logic              trig_acc,
  input  logic [DATA_W-1:0] smp_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W-1:0] last_addr
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      trig_addr <= '0;
      last_addr <= '0;
    end else begin
      wr_en <= wr_req;
      if (clr) begin
        ptr       <= '0;
        trig_addr <= '0;
        last_addr <= '0;
      end
      if (wr_req) begin
        wr_addr   <= ptr;
        wr_data   <= smp_data;
        last_addr <= ptr;
        ptr       <= ptr + 1'b1;
      end
      if (trig_acc)
        trig_addr <= ptr;
    end
  end

endmodule

// File: rtl/acq_seq_core.sv
module acq_seq_core
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 12,
  parameter int REC_W       = 16,
  parameter int DFLT_MARGIN = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig_in,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic [2:0]        mode_sel,
  input  logic [ADDR_W:0]   cnt_in,
  input  logic [REC_W-1:0]  rec_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [REC_W-1:0]  rec_count,
  output logic [ADDR_W-1:0] last_addr,
  output logic              done
);
  mode_t             mode_dec, mode_q;
  state_t            st_q;
  logic [ADDR_W:0]   cnt_eff, pre_need;
  logic [REC_W-1:0]  rec_tgt;
  logic              start_go, wr_req, trig_acc;

  acq_cfg_latch #(.ADDR_W(ADDR_W), .REC_W(REC_W), .DFLT_MARGIN(DFLT_MARGIN)) u_cfg (
    .clk(clk), .rst(rst), .load(start_go), .mode_sel(mode_sel), .cnt_in(cnt_in),
    .rec_in(rec_in), .mode_dec(mode_dec), .mode_q(mode_q), .cnt_eff(cnt_eff),
    .pre_need(pre_need), .rec_tgt(rec_tgt)
  );

  acq_ctrl #(.ADDR_W(ADDR_W), .REC_W(REC_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .smp_vld(smp_vld), .trig_in(trig_in), .mode_dec(mode_dec), .mode_q(mode_q),
    .cnt_eff(cnt_eff), .pre_need(pre_need), .rec_tgt(rec_tgt),
    .start_go(start_go), .wr_req(wr_req), .trig_acc(trig_acc), .st_q(st_q),
    .rec_count(rec_count), .done(done)
  );

  acq_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst), .clr(start_go), .wr_req(wr_req), .trig_acc(trig_acc),
    .smp_data(smp_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_addr(trig_addr), .last_addr(last_addr)
  );

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk
  import acq_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int REC_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_cmd,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] trig_addr,
  input logic [REC_W-1:0]  rec_count,
  input logic              done,
  input state_t            st
);

  AST_STOP_DONE: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && st != ST_IDLE) |=> (done && !wr_en)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == ST_IDLE)); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R9

  AST_WR_RUN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(st) != ST_IDLE)); // R9

  AST_REC_STEP: assert property (@(posedge clk) disable iff (rst)
    (rec_count != $past(rec_count)) |->
      (rec_count == REC_W'($past(rec_count) + 1'b1) || rec_count == '0)); // R6

  AST_FREE_TRIG: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FREE) |=> $stable(trig_addr)); // R5

endmodule

bind acq_seq_core acq_seq_chk #(.ADDR_W(ADDR_W), .REC_W(REC_W)) u_chk (
  .clk(clk), .rst(rst), .stop_cmd(stop_cmd), .wr_en(wr_en), .wr_addr(wr_addr),
  .trig_addr(trig_addr), .rec_count(rec_count), .done(done), .st(st_q)
);

// File: tb/acq_seq_core_tb_top.sv
module acq_seq_core_tb_top;
  localparam int AW    = 8;
  localparam int DW    = 12;
  localparam int RW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_vld = 1'b0, trig_in = 1'b0, start_cmd = 1'b0, stop_cmd = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [2:0]    mode_sel = '0;
  logic [AW:0]   cnt_in = '0;
  logic [RW-1:0] rec_in = '0;
  logic          wr_en, done;
  logic [AW-1:0] wr_addr, trig_addr, last_addr;
  logic [DW-1:0] wr_data;
  logic [RW-1:0] rec_count;

  int checks = 0, errors = 0;
  bit wd_hit = 0;

  // reference model state (0 idle, 1 history, 2 armed, 3 tail, 4 free)
  int m_st = 0, m_mode = 0, m_cnt = 0, m_need = 0, m_tgt = 1;
  int m_ptr = 0, m_seen = 0, m_left = 0, m_recs = 0;
  int e_en = 0, e_addr = 0, e_data = 0, e_done = 0, e_trig = 0, e_last = 0;

  always #5 clk = ~clk;

  acq_seq_core #(.ADDR_W(AW), .DATA_W(DW), .REC_W(RW), .DFLT_MARGIN(100)) dut_i (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data), .trig_in(trig_in),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .mode_sel(mode_sel), .cnt_in(cnt_in),
    .rec_in(rec_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_addr(trig_addr), .rec_count(rec_count), .last_addr(last_addr), .done(done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int md);
    case (md)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic m_write(input int d);
    e_en = 1; e_addr = m_ptr; e_data = d; e_last = m_ptr;
    m_ptr = (m_ptr + 1) % DEPTH;
  endtask

  task automatic m_end();
    if (m_mode == 4) begin
      m_recs++;
      if (m_recs >= m_tgt) begin m_st = 0; e_done = 1; end
      else m_st = 2;
    end else begin
      m_st = 0; e_done = 1;
    end
  endtask

  task automatic m_trigger(input int d);
    e_trig = m_ptr;
    m_write(d);
    m_left = m_cnt - 1;
    if (m_left == 0) m_end();
    else m_st = 3;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_ptr = 0; m_recs = 0;
      e_en = 0; e_addr = 0; e_data = 0; e_done = 0; e_trig = 0; e_last = 0;
    end else begin
      e_en = 0;
      if (m_st == 0) begin
        if (start_cmd) begin
          m_mode = (int'(mode_sel) >= 1 && int'(mode_sel) <= 4) ? int'(mode_sel) : 0;
          m_cnt  = (cnt_in == 0) ? DEPTH - 100 : ((int'(cnt_in) > DEPTH) ? DEPTH : int'(cnt_in));
          m_need = 0;
          if (m_mode == 1) m_need = DEPTH - m_cnt;
          if (m_mode == 2) begin m_cnt = DEPTH / 2; m_need = DEPTH / 2; end
          m_tgt  = (rec_in == 0) ? 1 : int'(rec_in);
          m_ptr = 0; m_seen = 0; m_recs = 0;
          e_done = 0; e_last = 0; e_trig = 0;
          m_st = (m_mode == 1 || m_mode == 2) ? 1 : ((m_mode == 3) ? 4 : 2);
        end
      end else if (stop_cmd) begin
        m_st = 0; e_done = 1;
      end else if (smp_vld) begin
        case (m_st)
          4: m_write(int'(smp_data));
          1: if (trig_in && m_seen >= m_need) m_trigger(int'(smp_data));
             else begin m_write(int'(smp_data)); m_seen++; end
          2: if (trig_in) m_trigger(int'(smp_data));
          3: begin
               m_write(int'(smp_data));
               m_left--;
               if (m_left == 0) m_end();
             end
          default: ;
        endcase
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !wd_hit) begin
      chk("R9", "wr_en", int'(wr_en), e_en);
      if (e_en != 0) begin
        chk(mode_tag(m_mode), "wr_addr", int'(wr_addr), e_addr);
        chk(mode_tag(m_mode), "wr_data", int'(wr_data), e_data);
      end
      chk("R8", "done", int'(done), e_done);
      chk("R7", "trig_addr", int'(trig_addr), e_trig);
      chk("R6", "rec_count", int'(rec_count), m_recs);
      chk("R8", "last_addr", int'(last_addr), e_last);
    end
  end

  task automatic cyc(input bit v, input bit t, input bit s, input bit p);
    @(negedge clk);
    smp_vld = v; trig_in = t; start_cmd = s; stop_cmd = p;
    smp_data = DW'($urandom);
  endtask

  task automatic begin_run(input int md, input int cnt, input int recs);
    mode_sel = 3'(md); cnt_in = (AW+1)'(cnt); rec_in = RW'(recs);
    cyc(0, 0, 1, 0);
  endtask

  task automatic run(input int n, input int vpct, input int tpct);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 100) < vpct, ($urandom % 100) < tpct, 0, 0);
  endtask

  task automatic hold(input int n, input bit v, input bit t);
    for (int i = 0; i < n; i++) cyc(v, t, 0, 0);
  endtask

  task automatic settle();
    hold(3, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "wr_en after reset", int'(wr_en), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "rec_count after reset", int'(rec_count), 0);
    chk("R1", "trig_addr after reset", int'(trig_addr), 0);
    chk("R1", "last_addr after reset", int'(last_addr), 0);
    hold(5, 1, 1);
    chk("R1", "no write before start", int'(wr_en), 0);

    // R2 post mode, count 5; R11 trigger without valid sample ignored
    begin_run(0, 5, 0);
    hold(3, 0, 1);
    hold(4, 1, 0);
    chk("R11", "no write from unqualified trigger", int'(wr_en), 0);
    hold(1, 1, 1);
    hold(6, 1, 0);
    settle();
    chk("R2", "post done", int'(done), 1);
    chk("R2", "post last_addr", int'(last_addr), 4);
    chk("R7", "post trig_addr", int'(trig_addr), 0);

    // R2 default count (0 -> depth-100) with unused code 6
    begin_run(6, 0, 0);
    hold(300, 1, 1);
    settle();
    chk("R2", "default count last_addr", int'(last_addr), DEPTH - 101);

    // R10 count above depth is clamped
    begin_run(0, 300, 0);
    hold(300, 1, 1);
    settle();
    chk("R10", "clamped count last_addr", int'(last_addr), DEPTH - 1);

    // R3 pre-trigger: trigger held high from the start
    begin_run(1, 20, 0);
    hold(300, 1, 1);
    settle();
    chk("R3", "pre trig_addr", int'(trig_addr), DEPTH - 20);
    chk("R3", "pre last_addr", int'(last_addr), DEPTH - 1);

    // R4 centre
    begin_run(2, 7, 0);
    hold(300, 1, 1);
    settle();
    chk("R4", "centre trig_addr", int'(trig_addr), DEPTH / 2);
    chk("R4", "centre last_addr", int'(last_addr), DEPTH - 1);

    // R6 record, trigger held: segments back to back
    begin_run(4, 3, 4);
    hold(30, 1, 1);
    settle();
    chk("R6", "record count", int'(rec_count), 4);
    chk("R6", "record last_addr", int'(last_addr), 11);
    chk("R7", "record trig_addr", int'(trig_addr), 9);

    // R6 target 0 acts as 1
    begin_run(4, 4, 0);
    hold(20, 1, 1);
    settle();
    chk("R6", "target zero count", int'(rec_count), 1);
    chk("R6", "target zero done", int'(done), 1);

    // R5 free run with wrap, then stop with a valid sample in the stop cycle
    begin_run(3, 9, 0);
    hold(300, 1, 1);
    cyc(1, 1, 0, 1);
    settle();
    chk("R5", "free trig_addr", int'(trig_addr), 0);
    chk("R8", "free stop last_addr", int'(last_addr), (300 - 1) % DEPTH);
    chk("R9", "free wrap done", int'(done), 1);

    // R10 start during a run ignored; stop while idle ignored
    begin_run(0, 10, 0);
    hold(1, 1, 1);
    hold(2, 1, 0);
    mode_sel = 3'd3;
    cyc(1, 0, 1, 0);
    hold(12, 1, 0);
    settle();
    chk("R10", "mid-run start ignored", int'(last_addr), 9);
    cyc(0, 0, 0, 1);
    settle();
    chk("R10", "idle stop keeps done", int'(done), 1);
    chk("R10", "idle stop keeps last_addr", int'(last_addr), 9);

    // R8 stop while armed, nothing written
    begin_run(0, 10, 0);
    hold(5, 1, 0);
    cyc(0, 0, 0, 1);
    settle();
    chk("R8", "stop armed done", int'(done), 1);
    chk("R8", "stop armed last_addr", int'(last_addr), 0);

    // random patterns in every mode, checked by the model
    for (int md = 0; md < 5; md++) begin
      begin_run(md, 17 + md * 11, 5);
      run(900, 70, 8);
      cyc(0, 0, 0, 1);
      settle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule